// File: doc/BRIEF.md
# Shared Free-Running Timer with Per-Context Compare

This block keeps one up-counter shared by every processor context in a cluster, and gives each context its own 64-bit compare value and timer interrupt line. The counter width is a parameter: a multiple of four from 32 to 64 bits. The width is published in a configuration word so that software can find out how many bits are live. A halt bit in the same word freezes the count without losing it.

Software reaches the block through a simple word-addressed register port. Each access carries the number of the context that issues it. The counter is read as two 32-bit words, and a reader that fetches upper, lower, then upper again can detect a carry between the two halves. A context writes its own compare value through two local words. Through a second pair of words it can reach the compare value of any context named in its own select register. A context's interrupt rises once the counter has reached its compare value, and it stays up until software writes either half of that compare value.

Top module: `gcnt_timer`

## Requirements
- R1: Synchronous reset gives these values: the counter is zero, the halt bit is clear, every select register is zero, every compare value is all ones, and every interrupt is low.
- R2: Word 0 is the configuration word. Bit 0 is the halt bit and can be read and written. Bits 7:4 are read-only and hold (CNT_W-32)/4, which is 4 for the default width of 48. All other bits read as zero.
- R3: The counter advances by one on every clock while the halt bit is clear. While the halt bit is set the counter holds its value. When the halt bit is cleared again, counting resumes from the held value.
- R4: Word 1 reads counter bits 31:0 and word 2 reads the bits above them. Bits at or above CNT_W read as zero. When the lower word rolls over, the upper word shows the carry in the same cycle.
- R5: The counter wraps to zero after the value 2^CNT_W-1.
- R6: A write to word 1 or word 2 loads that half of the counter, and bits at or above CNT_W are dropped. A load takes precedence over counting in that cycle.
- R7: Words 4 and 5 read and write the lower and upper halves of the compare value that belongs to the context named by acc_ctx.
- R8: Word 3 is the select register of the issuing context. Words 6 and 7 read and write the lower and upper halves of the compare value of the context held in that select register. One context's select register has no effect on any other context.
- R9: A context's interrupt rises on the clock edge after the counter, zero-extended to 64 bits, is unsigned greater than or equal to that context's compare value. Once set, the interrupt stays high, even across a counter wrap, until a compare half of that context is written.
- R10: A write to either half of a context's compare value clears its interrupt on that edge. The clear takes precedence over a match in the same cycle, and the new compare value is evaluated on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_ctx | input | CTX_W | Context that issues the current access |
| reg_we | input | 1 | Write strobe |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| timer_irq | output | NCTX | Timer interrupt, one bit per context |

## Verification
Two events can land on the same edge: a context's counter match, which would set its interrupt, and a software write to one of that context's compare halves, which clears it. The bench sets up this collision with an interrupt already pending while the counter runs above the compare value. It then rewrites the lower compare half with a value that is still below the counter. The bench expects the interrupt to be low in the cycle after the write and high again one cycle later. A second case writes a large upper half and expects the line to stay low. The carry between the two counter words is also timed to the cycle: the upper word is read on the exact cycle the lower word rolls over.

// File: rtl/gcnt_pkg.sv
package gcnt_pkg;

    // Word addresses of the register port. The bench and the checker
    // rely on these values.
    typedef enum logic [3:0] {
        RA_CFG     = 4'd0,
        RA_CNT_LO  = 4'd1,
        RA_CNT_HI  = 4'd2,
        RA_SEL     = 4'd3,
        RA_CMP_LO  = 4'd4,
        RA_CMP_HI  = 4'd5,
        RA_OCMP_LO = 4'd6,
        RA_OCMP_HI = 4'd7
    } reg_addr_e;

    localparam int HALT_BIT  = 0;
    localparam int WCODE_LSB = 4;
    localparam int WCODE_W   = 4;

    // Strobe for one half of a 64-bit value.
    typedef struct packed {
        logic hi;
        logic lo;
    } half_sel_t;

    // Encoded counter width as published in the configuration word.
    function automatic logic [WCODE_W-1:0] width_code(input int w);
        return WCODE_W'((w - 32) / 4);
    endfunction

endpackage

// File: rtl/gcnt_counter.sv
module gcnt_counter
    import gcnt_pkg::*;
#(
    parameter int CNT_W = 48
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        halt,
    input  half_sel_t   ld,
    input  logic [31:0] ld_data,
    output logic [63:0] cnt64
);

    logic [CNT_W-1:0] cnt_q;
    logic [63:0]      ext;

    // Everything outside this module sees the counter zero-extended to 64 bits.
    always_comb ext = 64'(cnt_q);

    // The count lives in one register, so a carry out of the lower word
    // shows in the upper word on the same edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (ld.lo) begin
            cnt_q <= CNT_W'({ext[63:32], ld_data});
        end else if (ld.hi) begin
            cnt_q <= CNT_W'({ld_data, ext[31:0]});
        end else if (!halt) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt64 = ext;

endmodule

// File: rtl/gcnt_cmp_ctx.sv
module gcnt_cmp_ctx (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] cnt64,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    output logic [63:0] cmp_q,
    output logic        irq_q
);

    logic hit;

    always_comb hit = (cnt64 >= cmp_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            irq_q <= 1'b0;
        end else begin
            if (wr_lo) cmp_q[31:0]  <= wdata;
            if (wr_hi) cmp_q[63:32] <= wdata;
            // A write to either half wins over a match in the same cycle.
            if (wr_lo || wr_hi) irq_q <= 1'b0;
            else if (hit)       irq_q <= 1'b1;
        end
    end

endmodule

// File: rtl/gcnt_timer.sv
module gcnt_timer
    import gcnt_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int NCTX  = 4,
    localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CTX_W-1:0] acc_ctx,
    input  logic             reg_we,
    input  logic [3:0]       reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic [NCTX-1:0]  timer_irq
);

    localparam logic [WCODE_W-1:0] WCODE = width_code(CNT_W);

    reg_addr_e        addr_e;
    logic             halt_q;
    logic [CTX_W-1:0] sel_q [NCTX];
    logic [CTX_W-1:0] sel_cur;
    half_sel_t        cnt_ld;
    logic             ld_any;
    logic [63:0]      cnt64;
    logic [63:0]      cmp_all [NCTX];
    logic [NCTX-1:0]  wr_lo;
    logic [NCTX-1:0]  wr_hi;

    always_comb begin
        addr_e    = reg_addr_e'(reg_addr);
        sel_cur   = sel_q[acc_ctx];
        cnt_ld.lo = reg_we && (addr_e == RA_CNT_LO);
        cnt_ld.hi = reg_we && (addr_e == RA_CNT_HI);
        ld_any    = cnt_ld.lo || cnt_ld.hi;
    end

    // Halt bit and the per-context select registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q <= 1'b0;
            for (int i = 0; i < NCTX; i++) sel_q[i] <= '0;
        end else if (reg_we) begin
            if (addr_e == RA_CFG) halt_q <= reg_wdata[HALT_BIT];
            if (addr_e == RA_SEL) sel_q[acc_ctx] <= reg_wdata[CTX_W-1:0];
        end
    end

    gcnt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .halt    (halt_q),
        .ld      (cnt_ld),
        .ld_data (reg_wdata),
        .cnt64   (cnt64)
    );

    // One compare slice per context. A slice can be written through the
    // local words by its own context, or through the other-context words
    // by any context whose select register names it.
    for (genvar g = 0; g < NCTX; g++) begin : g_ctx
        always_comb begin
            wr_lo[g] = reg_we &&
                       (((addr_e == RA_CMP_LO)  && (acc_ctx == CTX_W'(g))) ||
                        ((addr_e == RA_OCMP_LO) && (sel_cur == CTX_W'(g))));
            wr_hi[g] = reg_we &&
                       (((addr_e == RA_CMP_HI)  && (acc_ctx == CTX_W'(g))) ||
                        ((addr_e == RA_OCMP_HI) && (sel_cur == CTX_W'(g))));
        end

        gcnt_cmp_ctx u_cmp (
            .clk   (clk),
            .rst   (rst),
            .cnt64 (cnt64),
            .wr_lo (wr_lo[g]),
            .wr_hi (wr_hi[g]),
            .wdata (reg_wdata),
            .cmp_q (cmp_all[g]),
            .irq_q (timer_irq[g])
        );
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (addr_e)
            RA_CFG: begin
                reg_rdata[WCODE_LSB +: WCODE_W] = WCODE;
                reg_rdata[HALT_BIT]             = halt_q;
            end
            RA_CNT_LO:  reg_rdata = cnt64[31:0];
            RA_CNT_HI:  reg_rdata = cnt64[63:32];
            RA_SEL:     reg_rdata = 32'(sel_cur);
            RA_CMP_LO:  reg_rdata = cmp_all[acc_ctx][31:0];
            RA_CMP_HI:  reg_rdata = cmp_all[acc_ctx][63:32];
            RA_OCMP_LO: reg_rdata = cmp_all[sel_cur][31:0];
            RA_OCMP_HI: reg_rdata = cmp_all[sel_cur][63:32];
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gcnt_timer_chk.sv
module gcnt_timer_chk
    import gcnt_pkg::*;
#(
    parameter int CNT_W = 48,
    parameter int NCTX  = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [3:0]       reg_addr,
    input logic [31:0]      reg_rdata,
    input logic [NCTX-1:0]  timer_irq,
    input logic             halt_q,
    input logic             ld_any,
    input logic [63:0]      cnt64,
    input logic [63:0]      cmp_all [NCTX],
    input logic [NCTX-1:0]  wr_lo,
    input logic [NCTX-1:0]  wr_hi
);

    localparam logic [63:0] CNT_MASK =
        (CNT_W >= 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << CNT_W) - 64'd1);

    // R1: state after a reset edge
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (timer_irq == '0 && cnt64 == 64'd0 && !halt_q));

    p_halt_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (halt_q && !ld_any) |=> (cnt64 == $past(cnt64)));

    // R3 and R5: one step per cycle, modulo the configured width
    p_count_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!halt_q && !ld_any) |=> (cnt64 == (($past(cnt64) + 64'd1) & CNT_MASK)));

    p_hi_range_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == RA_CNT_HI) |-> (({reg_rdata, 32'h0} & ~CNT_MASK) == 64'd0));

    for (genvar g = 0; g < NCTX; g++) begin : g_ctx_chk
        p_irq_set_r9: assert property (@(posedge clk) disable iff (rst)
            (!wr_lo[g] && !wr_hi[g] && (cnt64 >= cmp_all[g])) |=> timer_irq[g]);

        p_irq_sticky_r9: assert property (@(posedge clk) disable iff (rst)
            (timer_irq[g] && !wr_lo[g] && !wr_hi[g]) |=> timer_irq[g]);

        p_irq_clear_r10: assert property (@(posedge clk) disable iff (rst)
            (wr_lo[g] || wr_hi[g]) |=> !timer_irq[g]);
    end

endmodule

bind gcnt_timer gcnt_timer_chk #(.CNT_W(CNT_W), .NCTX(NCTX)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .timer_irq (timer_irq),
    .halt_q    (halt_q),
    .ld_any    (ld_any),
    .cnt64     (cnt64),
    .cmp_all   (cmp_all),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi)
);

// File: tb/tb_gcnt_timer.sv
module tb_gcnt_timer;
    import gcnt_pkg::*;

    localparam int CNT_W = 48;
    localparam int NCTX  = 4;
    localparam int CTX_W = 2;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CTX_W-1:0] acc_ctx = '0;
    logic             reg_we = 1'b0;
    logic [3:0]       reg_addr = '0;
    logic [31:0]      reg_wdata = '0;
    logic [31:0]      reg_rdata;
    logic [NCTX-1:0]  timer_irq;

    gcnt_timer #(.CNT_W(CNT_W), .NCTX(NCTX)) dut (
        .clk       (clk),
        .rst       (rst),
        .acc_ctx   (acc_ctx),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .timer_irq (timer_irq)
    );

    always #10 clk = ~clk;

    int tick = 0;
    always @(posedge clk) tick <= tick + 1;

    typedef struct {
        int          tk;
        bit          is_irq;
        logic [31:0] exp;
        logic [31:0] mask;
        string       tag;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 1'b0;

    // Queue the expectation, kept in order of the tick at which it is due.
    task automatic push(input int tk, input bit is_irq, input logic [31:0] exp,
                        input logic [31:0] mask, input string tag);
        item_t it;
        int    pos;
        it.tk = tk; it.is_irq = is_irq; it.exp = exp; it.mask = mask; it.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].tk > tk) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, it);
    endtask

    // Monitor: samples between edges and compares due items.
    always begin
        @(negedge clk);
        #3;
        while (q.size() > 0 && q[0].tk <= tick) begin
            item_t it;
            logic [31:0] act;
            it = q.pop_front();
            n_chk++;
            act = it.is_irq ? 32'(timer_irq) : reg_rdata;
            if (it.tk < tick) begin
                n_err++;
                $display("FAIL %s missed sample tick %0d (actual 0x%08h expected 0x%08h)",
                         it.tag, it.tk, act, it.exp);
            end else if ((act & it.mask) != (it.exp & it.mask)) begin
                n_err++;
                $display("FAIL %s %s actual 0x%08h expected 0x%08h", it.tag,
                         it.is_irq ? "irq" : "rdata", act & it.mask, it.exp & it.mask);
            end
        end
    end

    task automatic wr(input int ctx, input reg_addr_e a, input logic [31:0] d);
        acc_ctx = CTX_W'(ctx); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ctx, input reg_addr_e a, input logic [31:0] e,
                      input string tag);
        reg_we = 1'b0; acc_ctx = CTX_W'(ctx); reg_addr = a;
        push(tick, 1'b0, e, 32'hFFFF_FFFF, tag);
        @(negedge clk);
    endtask

    task automatic irq_at(input int dt, input logic [31:0] e, input logic [31:0] m,
                          input string tag);
        push(tick + dt, 1'b1, e, m, tag);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired (actual hung, expected completion)");
        summary();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1 and R2: reset values, read while reset is held
        rd(0, RA_CNT_LO, 32'h0, "R1");
        rd(0, RA_CMP_LO, 32'hFFFF_FFFF, "R1");
        irq_at(0, 32'h0, 32'hF, "R1");
        rd(0, RA_CFG, 32'h0000_0040, "R2");
        rst = 1'b0;

        // R8: other-context access through the select register
        wr(0, RA_SEL, 32'd2);
        wr(0, RA_OCMP_LO, 32'h0000_1234);
        rd(2, RA_CMP_LO, 32'h0000_1234, "R8");
        rd(0, RA_CMP_LO, 32'hFFFF_FFFF, "R8");
        rd(1, RA_SEL, 32'd0, "R8");
        rd(0, RA_SEL, 32'd2, "R8");
        rd(2, RA_OCMP_LO, 32'hFFFF_FFFF, "R8");

        // R7: local compare words
        wr(1, RA_CMP_LO, 32'h0000_ABCD);
        rd(1, RA_CMP_LO, 32'h0000_ABCD, "R7");
        rd(1, RA_CMP_HI, 32'hFFFF_FFFF, "R7");

        // R2 and R6: halt, then load the counter
        wr(0, RA_CFG, 32'h1);
        rd(0, RA_CFG, 32'h0000_0041, "R2");
        wr(0, RA_CNT_HI, 32'h0);
        wr(0, RA_CNT_LO, 32'd100);
        rd(0, RA_CNT_LO, 32'd100, "R6");
        wr(0, RA_CMP_HI, 32'h0);
        wr(0, RA_CMP_LO, 32'd103);
        irq_at(0, 32'h0, 32'h1, "R9");

        // R9: the counter reaches 103 three edges after resume, the irq one edge later
        wr(0, RA_CFG, 32'h0);
        irq_at(0, 32'h0, 32'h1, "R9");
        irq_at(1, 32'h0, 32'h1, "R9");
        irq_at(2, 32'h0, 32'h1, "R9");
        irq_at(3, 32'h0, 32'h1, "R9");
        irq_at(4, 32'h1, 32'h1, "R9");
        idle(6);

        // R10: the write clears the irq even though the counter is above compare
        wr(0, RA_CMP_LO, 32'd50);
        irq_at(0, 32'h0, 32'h1, "R10");
        irq_at(1, 32'h1, 32'h1, "R10");
        idle(2);
        wr(0, RA_CMP_HI, 32'd7);
        irq_at(0, 32'h0, 32'h1, "R10");
        irq_at(3, 32'h0, 32'h1, "R10");
        idle(4);

        // Context 1 compare = 0: its irq sets and must stay set (R9)
        wr(1, RA_CMP_HI, 32'h0);
        wr(1, RA_CMP_LO, 32'h0);
        irq_at(1, 32'h2, 32'h2, "R9");
        idle(2);

        // R4: carry is seen in the upper word as the lower word rolls over
        wr(0, RA_CFG, 32'h1);
        wr(0, RA_CNT_HI, 32'd5);
        wr(0, RA_CNT_LO, 32'hFFFF_FFFE);
        wr(0, RA_CFG, 32'h0);
        rd(0, RA_CNT_HI, 32'd5, "R4");
        rd(0, RA_CNT_LO, 32'hFFFF_FFFF, "R4");
        rd(0, RA_CNT_HI, 32'd6, "R4");
        rd(0, RA_CNT_LO, 32'd1, "R4");

        // R3: halt holds the count; resume continues from it
        wr(0, RA_CFG, 32'h1);
        rd(0, RA_CNT_LO, 32'd3, "R3");
        idle(5);
        rd(0, RA_CNT_LO, 32'd3, "R3");
        wr(0, RA_CFG, 32'h0);
        rd(0, RA_CNT_LO, 32'd3, "R3");
        rd(0, RA_CNT_LO, 32'd4, "R3");

        // R4, R6 and R5: width masking and wrap at 2^48
        wr(0, RA_CFG, 32'h1);
        wr(0, RA_CNT_HI, 32'hFFFF_FFFF);
        rd(0, RA_CNT_HI, 32'h0000_FFFF, "R4");
        wr(0, RA_CNT_LO, 32'hFFFF_FFFE);
        wr(0, RA_CFG, 32'h0);
        rd(0, RA_CNT_LO, 32'hFFFF_FFFE, "R5");
        rd(0, RA_CNT_LO, 32'hFFFF_FFFF, "R5");
        rd(0, RA_CNT_HI, 32'h0, "R5");
        rd(0, RA_CNT_LO, 32'd1, "R5");
        irq_at(0, 32'h2, 32'h2, "R9");
        idle(2);

        while (q.size() > 0) idle(1);
        idle(1);
        summary();
    end

endmodule